// File: doc/BRIEF.md
# Interrupt and clock interlock status register

This block keeps one read-only status byte that records three kinds of state. The first is which interrupt priority levels are in service. The second is whether the crystal oscillator has warmed up. The third is which serial ports are moving a frame. The interrupt controller, the oscillator control and the serial ports feed it single-cycle event pulses, and each status bit is held in a flop that those pulses set and clear.

Two of these bits are also used to guard the clock controls. While the crystal is not ready, the block keeps the clock-source select from moving to the crystal. While any serial port is busy and the switchback feature is on, it holds back writes to the clock-divide bits. It drives both guards as permit flags that the clock-control register logic combines with its own write strobes. Software has no write path into the status byte.

Top module: `irq_clk_status`

## Requirements
- R1: Status byte layout: bit 7 reads 0, bit 6 = high level in service, bit 5 = low level in service, bit 4 = crystal warm, bit 3 = port 1 sending, bit 2 = port 1 receiving, bit 1 = port 0 sending, bit 0 = port 0 receiving. After reset the byte reads 0x10.
- R2: An entry pulse for the high level sets bit 6, and an entry pulse for the low level sets bit 5. Either change is visible one clock after the pulse.
- R3: A return pulse clears bit 6 if it is set, and otherwise clears bit 5. An entry pulse in the same cycle as a return leaves the bit of the level being entered set.
- R4: The warm bit is 1 out of reset. It is cleared one clock after a power-down exit pulse or a crystal-off pulse. When a restart and a ready detect fall in the same cycle, the restart wins.
- R5: A crystal-ready detect with no restart in the same cycle sets the warm bit one clock later.
- R6: Each serial activity bit is set one clock after its start pulse and cleared one clock after its done flag. When start and done fall in the same cycle, start wins.
- R7: `xtal_sel_ok` is high exactly when the warm bit is 1.
- R8: `div_wr_ok` is low while `swb_en` is high and any activity bit is 1. Otherwise it is high. It follows `swb_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_enter_hi | input | 1 | High-level service routine begins |
| irq_enter_lo | input | 1 | Low-level service routine begins |
| irq_return | input | 1 | Return from a service routine |
| pd_exit | input | 1 | Oscillator restart on exit from power-down |
| xtal_off_set | input | 1 | Oscillator restart because crystal-off was set |
| xtal_ready | input | 1 | Crystal clock detected stable |
| tx_start | input | NUM_PORTS | Per-port transmit begins |
| rx_start | input | NUM_PORTS | Per-port receive begins |
| tx_done | input | NUM_PORTS | Per-port hardware transmit-done flag |
| rx_done | input | NUM_PORTS | Per-port hardware receive-done flag |
| swb_en | input | 1 | Switchback enabled |
| status_o | output | 8 | Status byte |
| xtal_sel_ok | output | 1 | Crystal may be selected as clock source |
| div_wr_ok | output | 1 | Clock-divide bits may be changed |

## Verification
Several pairs of events can land in the same cycle, and each pair is resolved by a fixed rule. A return can arrive with an entry, a restart can arrive with the ready detect, and a port's start can arrive with its done flag. The bench drives each pair with both pulses in one cycle, from states where the outcome differs. Examples are a return taken with the high level set and with it clear, and a done flag arriving on an idle lane and on a busy one. The resulting byte and both permit flags are then compared against a model built from the resolution rules above.

// File: rtl/irqclk_pkg.sv
package irqclk_pkg;
   localparam int STAT_W    = 8;
   localparam int BIT_HIP   = 6;
   localparam int BIT_LIP   = 5;
   localparam int BIT_WARM  = 4;
   localparam int MAX_PORTS = 2;
   localparam int LANE_BITS = 2;
   // per-port lane position within the activity nibble
   localparam int LANE_RX   = 0;
   localparam int LANE_TX   = 1;
endpackage

// File: rtl/isr_level_track.sv
module isr_level_track (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_hi,
   input  logic enter_lo,
   input  logic ret,
   output logic hi_q,
   output logic lo_q
);
   logic hi_n, lo_n;

   always_comb begin
      hi_n = (hi_q & ~ret) | enter_hi;
      lo_n = (lo_q & ~(ret & ~hi_q)) | enter_lo;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= hi_n;
         lo_q <= lo_n;
      end
   end

   // R2
   hi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter_hi |=> hi_q);
   // R2
   lo_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter_lo |=> lo_q);
   // R3
   hi_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_q && ret && !enter_hi) |=> !hi_q);
   // R3
   lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_q && ret && !enter_lo) |=> (lo_q == $past(lo_q)));
endmodule

// File: rtl/xtal_warm_track.sv
module xtal_warm_track #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_exit,
   input  logic xtal_off_set,
   input  logic ready,
   output logic warm_q
);
   logic rdy_s;
   logic restart;

   assign restart = pd_exit | xtal_off_set;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad
         $error("xtal_warm_track: SYNC_STAGES must be 0..3");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign rdy_s = ready;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= (sh << 1) | SYNC_STAGES'(ready);
         end
         assign rdy_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       warm_q <= 1'b1;
      else if (restart) warm_q <= 1'b0;
      else if (rdy_s)   warm_q <= 1'b1;
   end

   // R4
   warm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_exit || xtal_off_set) |=> !warm_q);

   generate
      if (SYNC_STAGES == 0) begin : g_rdy_chk
         // R5
         warm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && !pd_exit && !xtal_off_set) |=> warm_q);
      end
   endgenerate
endmodule

// File: rtl/serial_act_track.sv
module serial_act_track #(
   parameter bit START_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy_q
);
   generate
      if (START_WINS) begin : g_start_first
         always_ff @(posedge clk) begin
            if (!rst_n)     busy_q <= 1'b0;
            else if (start) busy_q <= 1'b1;
            else if (done)  busy_q <= 1'b0;
         end
         // R6
         act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> busy_q);
         // R6
         act_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !start) |=> !busy_q);
      end else begin : g_done_first
         always_ff @(posedge clk) begin
            if (!rst_n)     busy_q <= 1'b0;
            else if (done)  busy_q <= 1'b0;
            else if (start) busy_q <= 1'b1;
         end
         // R6
         act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (start && !done) |=> busy_q);
         // R6
         act_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> !busy_q);
      end
   endgenerate
endmodule

// File: rtl/irq_clk_status.sv
module irq_clk_status
   import irqclk_pkg::*;
#(
   parameter int NUM_PORTS   = 2,
   parameter int SYNC_STAGES = 0,
   parameter bit START_WINS  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 irq_enter_hi,
   input  logic                 irq_enter_lo,
   input  logic                 irq_return,
   input  logic                 pd_exit,
   input  logic                 xtal_off_set,
   input  logic                 xtal_ready,
   input  logic [NUM_PORTS-1:0] tx_start,
   input  logic [NUM_PORTS-1:0] rx_start,
   input  logic [NUM_PORTS-1:0] tx_done,
   input  logic [NUM_PORTS-1:0] rx_done,
   input  logic                 swb_en,
   output logic [STAT_W-1:0]    status_o,
   output logic                 xtal_sel_ok,
   output logic                 div_wr_ok
);
   localparam int ACT_W = NUM_PORTS * LANE_BITS;

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
         $error("irq_clk_status: NUM_PORTS must be 1..%0d", MAX_PORTS);
      end
   endgenerate

   logic                 hi_q, lo_q, warm_q;
   logic [NUM_PORTS-1:0] tx_busy, rx_busy;
   logic [ACT_W-1:0]     act_vec;
   logic                 act_any;

   isr_level_track u_isr (
      .clk      (clk),
      .rst_n    (rst_n),
      .enter_hi (irq_enter_hi),
      .enter_lo (irq_enter_lo),
      .ret      (irq_return),
      .hi_q     (hi_q),
      .lo_q     (lo_q)
   );

   xtal_warm_track #(.SYNC_STAGES(SYNC_STAGES)) u_warm (
      .clk          (clk),
      .rst_n        (rst_n),
      .pd_exit      (pd_exit),
      .xtal_off_set (xtal_off_set),
      .ready        (xtal_ready),
      .warm_q       (warm_q)
   );

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         serial_act_track #(.START_WINS(START_WINS)) u_tx (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (tx_start[p]),
            .done   (tx_done[p]),
            .busy_q (tx_busy[p])
         );
         serial_act_track #(.START_WINS(START_WINS)) u_rx (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (rx_start[p]),
            .done   (rx_done[p]),
            .busy_q (rx_busy[p])
         );
         assign act_vec[p*LANE_BITS + LANE_RX] = rx_busy[p];
         assign act_vec[p*LANE_BITS + LANE_TX] = tx_busy[p];
      end
   endgenerate

   assign act_any = |act_vec;

   always_comb begin
      status_o           = '0;
      status_o[BIT_HIP]  = hi_q;
      status_o[BIT_LIP]  = lo_q;
      status_o[BIT_WARM] = warm_q;
      status_o[ACT_W-1:0] = act_vec;
   end

   assign xtal_sel_ok = warm_q;
   assign div_wr_ok   = ~(swb_en & act_any);

   // R7
   xsel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(pd_exit) || $past(xtal_off_set))) |-> !xtal_sel_ok);

   generate
      if (START_WINS) begin : g_lock_chk
         // R8
         div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rx_start[0]) && swb_en) |-> !div_wr_ok);
      end
   endgenerate

   // R8
   div_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !swb_en |-> div_wr_ok);
endmodule

// File: tb/sim_irq_clk_status.sv
`timescale 1ns/1ps
module sim_irq_clk_status;
   localparam int NP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_enter_hi = 0, irq_enter_lo = 0, irq_return = 0;
   logic pd_exit = 0, xtal_off_set = 0, xtal_ready = 0, swb_en = 0;
   logic [NP-1:0] tx_start = '0, rx_start = '0, tx_done = '0, rx_done = '0;
   logic [7:0] status_o;
   logic xtal_sel_ok, div_wr_ok;

   always #2.5 clk = ~clk;

   irq_clk_status #(.NUM_PORTS(NP)) u0 (
      .clk(clk), .rst_n(rst_n),
      .irq_enter_hi(irq_enter_hi), .irq_enter_lo(irq_enter_lo),
      .irq_return(irq_return), .pd_exit(pd_exit),
      .xtal_off_set(xtal_off_set), .xtal_ready(xtal_ready),
      .tx_start(tx_start), .rx_start(rx_start),
      .tx_done(tx_done), .rx_done(rx_done), .swb_en(swb_en),
      .status_o(status_o), .xtal_sel_ok(xtal_sel_ok), .div_wr_ok(div_wr_ok)
   );

   typedef struct {
      logic [7:0] st;
      logic       xs;
      logic       dv;
   } exp_t;
   exp_t exp_q[$];

   int checks = 0;
   int fails  = 0;
   bit done_flag = 0;

   // model state, written from the requirements
   logic m_hi = 0, m_lo = 0, m_warm = 1;
   logic [NP-1:0] m_tx = '0, m_rx = '0;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic ehi, input logic elo, input logic ret,
                       input logic pdx, input logic xoff, input logic rdy,
                       input logic [NP-1:0] txs, input logic [NP-1:0] rxs,
                       input logic [NP-1:0] txd, input logic [NP-1:0] rxd,
                       input logic swb);
      exp_t e;
      logic n_hi, n_lo;
      @(negedge clk);
      irq_enter_hi = ehi; irq_enter_lo = elo; irq_return = ret;
      pd_exit = pdx; xtal_off_set = xoff; xtal_ready = rdy;
      tx_start = txs; rx_start = rxs; tx_done = txd; rx_done = rxd; swb_en = swb;
      // R2 / R3: return clears high level first, entry wins its own bit
      n_hi = (m_hi && !ret) || ehi;
      n_lo = (m_lo && !(ret && !m_hi)) || elo;
      m_hi = n_hi; m_lo = n_lo;
      // R4 / R5: restart beats ready
      if (pdx || xoff) m_warm = 0;
      else if (rdy)    m_warm = 1;
      // R6: start beats done
      for (int p = 0; p < NP; p++) begin
         if (txs[p]) m_tx[p] = 1; else if (txd[p]) m_tx[p] = 0;
         if (rxs[p]) m_rx[p] = 1; else if (rxd[p]) m_rx[p] = 0;
      end
      e.st = {1'b0, m_hi, m_lo, m_warm, m_tx[1], m_rx[1], m_tx[0], m_rx[0]};
      e.xs = m_warm;
      e.dv = !(swb && ((|m_tx) || (|m_rx)));
      exp_q.push_back(e);
   endtask

   task automatic idle(input logic swb);
      step(0,0,0, 0,0,0, '0,'0,'0,'0, swb);
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      #1;
      if (rst_n && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk("R1 bit7",        {7'd0, status_o[7]},   8'd0);
         chk("R2_R3 levels",   {6'd0, status_o[6:5]}, {6'd0, e.st[6:5]});
         chk("R4_R5 warm",     {7'd0, status_o[4]},   {7'd0, e.st[4]});
         chk("R6 activity",    {4'd0, status_o[3:0]}, {4'd0, e.st[3:0]});
         chk("R7 xtal_sel_ok", {7'd0, xtal_sel_ok},   {7'd0, e.xs});
         chk("R8 div_wr_ok",   {7'd0, div_wr_ok},     {7'd0, e.dv});
      end
   end

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #0.1;
      // R1 reset value, R7 and R8 permits out of reset
      chk("R1 reset byte", status_o, 8'h10);
      chk("R7 reset", {7'd0, xtal_sel_ok}, 8'd1);
      chk("R8 reset", {7'd0, div_wr_ok}, 8'd1);

      // R2 entries, R3 return ordering
      step(1,0,0, 0,0,0, '0,'0,'0,'0, 0);
      step(0,1,0, 0,0,0, '0,'0,'0,'0, 0);
      step(0,0,1, 0,0,0, '0,'0,'0,'0, 0);   // clears high only
      step(0,0,1, 0,0,0, '0,'0,'0,'0, 0);   // then low
      step(0,0,1, 0,0,0, '0,'0,'0,'0, 0);   // nothing to clear
      // R3 collisions
      step(0,1,1, 0,0,0, '0,'0,'0,'0, 0);   // low enters with return, high clear
      step(1,0,0, 0,0,0, '0,'0,'0,'0, 0);
      step(1,0,1, 0,0,0, '0,'0,'0,'0, 0);   // high re-entered with return
      step(0,1,1, 0,0,0, '0,'0,'0,'0, 0);   // high clears, low enters
      step(0,0,1, 0,0,0, '0,'0,'0,'0, 0);
      step(0,0,1, 0,0,0, '0,'0,'0,'0, 0);

      // R4 / R5 / R7 warm-up
      step(0,0,0, 1,0,0, '0,'0,'0,'0, 0);
      idle(0);
      step(0,0,0, 0,0,1, '0,'0,'0,'0, 0);
      step(0,0,0, 0,1,1, '0,'0,'0,'0, 0);   // restart beats ready
      step(0,0,0, 0,0,1, '0,'0,'0,'0, 0);
      step(0,0,0, 1,1,0, '0,'0,'0,'0, 0);
      step(0,0,0, 0,0,1, '0,'0,'0,'0, 0);

      // R6 / R8 activity and divide interlock
      step(0,0,0, 0,0,0, 2'b01,'0,'0,'0, 1);
      idle(0);
      idle(1);
      step(0,0,0, 0,0,0, '0,'0,2'b01,'0, 1);
      step(0,0,0, 0,0,0, '0,2'b10,'0,2'b10, 1); // start and done together
      step(0,0,0, 0,0,0, '0,'0,'0,2'b10, 1);
      step(0,0,0, 0,0,0, 2'b10,2'b01,'0,'0, 1);
      step(0,0,0, 0,0,0, 2'b10,'0,2'b10,2'b01, 1); // tx1 restarts, rx0 ends
      step(0,0,0, 0,0,0, '0,'0,2'b11,2'b11, 1);
      step(0,0,0, 0,0,0, '0,'0,2'b01,'0, 1);    // done on idle lane

      // mixed: all event classes in one cycle
      step(1,1,0, 1,0,1, 2'b11,2'b11,'0,'0, 1);
      step(0,0,1, 0,0,1, '0,'0,2'b11,2'b11, 0);
      step(0,0,1, 0,0,0, '0,'0,'0,'0, 1);
      idle(0);

      wait (exp_q.size() == 0);
      @(negedge clk);
      finish_run();
   end
endmodule